// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Page-Table Refill

The block turns a virtual address into a physical address. The virtual page number selects a set and a tag. The page offset passes through unchanged. A hit answers from the buffer one cycle after the request is accepted. A miss fetches one page-table word from memory at the table base plus four times the page number. The fetched entry is then installed, and the translation finishes from that data.

Each response reports the read-only and no-cache attributes of the page. It also flags two faults. A page fault means the page is absent. A protection fault means a write was made to a read-only page. Writes to writable pages mark the entry dirty. When a dirty entry is evicted, the block emits a one-cycle notice so the page can be written back to backing store. The policy that picks the victim is a parameter: least recently used, least frequently used, or pseudo-random. A flush input drops every entry at once.

Top module: `tlb_xlate`

## Requirements
- R1: A request accepted in cycle N that hits gives rsp_valid_o in cycle N+1 with no memory request. rsp_paddr_o is the stored block number followed by the unchanged page offset (low 12 bits by default).
- R2: A miss raises busy_o from the cycle after acceptance until the response cycle. It issues a memory read at byte address ptbr_i + 4 × page number, where ptbr_i is sampled at acceptance.
- R3: A page-table word carries the present flag in bit 0, the read-only flag in bit 1, the no-cache flag in bit 2, and the block number in bits 31:12. A present entry fetched on a miss is installed, so the next access to that page hits.
- R4: A fetched word with the present flag at 0 gives a response with rsp_page_fault_o set. The entry is not installed, so a repeat access misses again.
- R5: A write to a read-only page gives rsp_prot_fault_o, and the entry's dirty state is left unchanged. A read of the same page gives no fault and reports rsp_ro_o = 1.
- R6: rsp_nc_o reports the no-cache flag of the page, on both hits and refills.
- R7: mem_req_valid_o stays high with a stable mem_req_addr_o until mem_req_ready_i is seen. The response follows the cycle in which mem_rsp_valid_i is high.
- R8: The set index is the low 4 bits of the page number (default sizes). A fill uses the lowest invalid way first. Otherwise the default policy replaces the least recently used way, and both hits and fills count as uses.
- R9: Evicting a valid dirty entry pulses wb_valid_o with that entry's page number on wb_vpn_o, in the response cycle of the refill. Evicting a clean entry gives no pulse.
- R10: flush_i invalidates every entry in one cycle. A request presented while flush_i is high is not accepted.
- R11: After reset the buffer is empty, and busy_o, rsp_valid_o, wb_valid_o and mem_req_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| ptbr_i | input | PA_W | Page-table base byte address |
| req_valid_i | input | 1 | Translation request, taken when busy_o is low |
| req_vaddr_i | input | VA_W | Virtual address |
| req_write_i | input | 1 | 1 for a write access |
| busy_o | output | 1 | Refill in progress |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_paddr_o | output | PA_W | Physical address |
| rsp_ro_o | output | 1 | Page is read-only |
| rsp_nc_o | output | 1 | Page is not cacheable |
| rsp_page_fault_o | output | 1 | Page not present |
| rsp_prot_fault_o | output | 1 | Write to read-only page |
| wb_valid_o | output | 1 | Dirty entry evicted |
| wb_vpn_o | output | VA_W-PAGE_BITS | Page number of evicted dirty entry |
| mem_req_valid_o | output | 1 | Page-table read request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_addr_o | output | PA_W | Page-table entry byte address |
| mem_rsp_valid_i | input | 1 | Page-table word returned |
| mem_rsp_data_i | input | PTE_W | Page-table word |

## Verification
Wrong tag or valid state shows up in the very next response. A lost entry brings a memory request and a multi-cycle latency where one cycle was due. A stale entry gives a wrong physical address with no memory request. Errors in the recency or dirty state stay hidden until a set fills. They then appear as the wrong page missing after the next eviction, or as a missing or spurious write-back pulse. The bench therefore fills sets beyond their ways and probes which pages survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} tlb_state_e;

  localparam int unsigned REPL_LRU  = 0;
  localparam int unsigned REPL_LFU  = 1;
  localparam int unsigned REPL_RAND = 2;

  localparam int unsigned PTE_PRESENT_BIT = 0;
  localparam int unsigned PTE_RO_BIT      = 1;
  localparam int unsigned PTE_NC_BIT      = 2;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    hit_o = |eq;
    way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) if (eq[w]) way_o = WAY_W'(w);
  end
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl import tlb_pkg::*; #(
  parameter int unsigned WAYS   = 4,
  parameter int unsigned SETS   = 16,
  parameter int unsigned POLICY = REPL_LRU,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  set_i,
  input  logic [WAYS-1:0]   valid_i,
  input  logic              touch_i,
  input  logic              fill_i,
  input  logic [WAY_W-1:0]  way_i,
  output logic [WAY_W-1:0]  victim_o
);
  localparam int unsigned CNT_W = 4;

  logic             has_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] old_way;

  always_comb begin
    has_free = ~&valid_i;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) if (!valid_i[w]) free_way = WAY_W'(w);
  end

  assign victim_o = has_free ? free_way : old_way;

  if (POLICY == REPL_LFU) begin : g_lfu
    logic [WAYS-1:0][CNT_W-1:0] cnt_q [SETS];
    always_comb begin
      logic [CNT_W-1:0] best;
      best    = cnt_q[set_i][0];
      old_way = '0;
      for (int w = 1; w < WAYS; w++)
        if (cnt_q[set_i][w] < best) begin
          best    = cnt_q[set_i][w];
          old_way = WAY_W'(w);
        end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++) cnt_q[s] <= '0;
      end else if (fill_i) begin
        cnt_q[set_i][way_i] <= CNT_W'(1);
      end else if (touch_i && (cnt_q[set_i][way_i] != '1)) begin
        cnt_q[set_i][way_i] <= cnt_q[set_i][way_i] + 1'b1;
      end
    end
  end else if (POLICY == REPL_RAND) begin : g_rand
    logic [7:0] lfsr_q;
    assign old_way = lfsr_q[WAY_W-1:0];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lfsr_q <= 8'h01;
      else         lfsr_q <= {lfsr_q[6:0], lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3]};
    end
  end else begin : g_lru
    // ages in each set always form a permutation of 0..WAYS-1
    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    always_comb begin
      old_way = '0;
      for (int w = 0; w < WAYS; w++)
        if (age_q[set_i][w] == WAY_W'(WAYS-1)) old_way = WAY_W'(w);
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end else if (touch_i || fill_i) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == way_i) age_q[set_i][w] <= '0;
          else if (age_q[set_i][w] < age_q[set_i][way_i])
            age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate import tlb_pkg::*; #(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned ENTRIES   = 64,
  parameter int unsigned WAYS      = 4,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned POLICY    = REPL_LRU
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic [PA_W-1:0]           ptbr_i,
  input  logic                      req_valid_i,
  input  logic [VA_W-1:0]           req_vaddr_i,
  input  logic                      req_write_i,
  output logic                      busy_o,
  output logic                      rsp_valid_o,
  output logic [PA_W-1:0]           rsp_paddr_o,
  output logic                      rsp_ro_o,
  output logic                      rsp_nc_o,
  output logic                      rsp_page_fault_o,
  output logic                      rsp_prot_fault_o,
  output logic                      wb_valid_o,
  output logic [VA_W-PAGE_BITS-1:0] wb_vpn_o,
  output logic                      mem_req_valid_o,
  input  logic                      mem_req_ready_i,
  output logic [PA_W-1:0]           mem_req_addr_o,
  input  logic                      mem_rsp_valid_i,
  input  logic [PTE_W-1:0]          mem_rsp_data_i
);
  localparam int unsigned SETS  = ENTRIES / WAYS;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;
  localparam int unsigned PPN_W = PA_W - PAGE_BITS;
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  tlb_state_e                  state_q;
  logic [VA_W-1:0]             va_q;
  logic                        wr_q;
  logic [PA_W-1:0]             ptbr_q;

  logic [WAYS-1:0]             vld_q [SETS];
  logic [WAYS-1:0]             ro_q  [SETS];
  logic [WAYS-1:0]             nc_q  [SETS];
  logic [WAYS-1:0]             dty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
  logic [WAYS-1:0][PPN_W-1:0]  ppn_q [SETS];

  logic                        rsp_valid_q, rsp_ro_q, rsp_nc_q, rsp_pf_q, rsp_prot_q;
  logic [PA_W-1:0]             rsp_paddr_q;
  logic                        wb_valid_q;
  logic [VPN_W-1:0]            wb_vpn_q;

  logic [VPN_W-1:0]            cur_vpn;
  logic [IDX_W-1:0]            cur_set;
  logic [TAG_W-1:0]            cur_tag;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way, victim;
  logic                        accept, fill;
  logic                        pte_present, pte_ro, pte_nc;
  logic [PPN_W-1:0]            pte_ppn;

  assign cur_vpn = (state_q == ST_IDLE) ? req_vaddr_i[VA_W-1:PAGE_BITS] : va_q[VA_W-1:PAGE_BITS];
  assign cur_set = cur_vpn[IDX_W-1:0];
  assign cur_tag = cur_vpn[VPN_W-1:IDX_W];

  assign accept      = req_valid_i && (state_q == ST_IDLE) && !flush_i;
  assign pte_present = mem_rsp_data_i[PTE_PRESENT_BIT];
  assign pte_ro      = mem_rsp_data_i[PTE_RO_BIT];
  assign pte_nc      = mem_rsp_data_i[PTE_NC_BIT];
  assign pte_ppn     = mem_rsp_data_i[PTE_W-1 -: PPN_W];
  assign fill        = (state_q == ST_WAIT) && mem_rsp_valid_i && pte_present;

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .valid_i (vld_q[cur_set]),
    .tags_i  (tag_q[cur_set]),
    .tag_i   (cur_tag),
    .hit_o   (hit),
    .way_o   (hit_way)
  );

  tlb_repl #(.WAYS(WAYS), .SETS(SETS), .POLICY(POLICY)) u_repl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cur_set),
    .valid_i  (vld_q[cur_set]),
    .touch_i  (accept && hit),
    .fill_i   (fill),
    .way_i    (fill ? victim : hit_way),
    .victim_o (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      ptbr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_ro_q    <= 1'b0;
      rsp_nc_q    <= 1'b0;
      rsp_pf_q    <= 1'b0;
      rsp_prot_q  <= 1'b0;
      wb_valid_q  <= 1'b0;
      wb_vpn_q    <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        ro_q[s]  <= '0;
        nc_q[s]  <= '0;
        dty_q[s] <= '0;
        tag_q[s] <= '0;
        ppn_q[s] <= '0;
      end
    end else begin
      rsp_valid_q <= 1'b0;
      wb_valid_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          va_q   <= req_vaddr_i;
          wr_q   <= req_write_i;
          ptbr_q <= ptbr_i;
          if (hit) begin
            rsp_valid_q <= 1'b1;
            rsp_paddr_q <= {ppn_q[cur_set][hit_way], req_vaddr_i[PAGE_BITS-1:0]};
            rsp_ro_q    <= ro_q[cur_set][hit_way];
            rsp_nc_q    <= nc_q[cur_set][hit_way];
            rsp_pf_q    <= 1'b0;
            rsp_prot_q  <= req_write_i && ro_q[cur_set][hit_way];
            if (req_write_i && !ro_q[cur_set][hit_way]) dty_q[cur_set][hit_way] <= 1'b1;
          end else begin
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          state_q     <= ST_IDLE;
          rsp_valid_q <= 1'b1;
          rsp_paddr_q <= {pte_ppn, va_q[PAGE_BITS-1:0]};
          rsp_ro_q    <= pte_ro;
          rsp_nc_q    <= pte_nc;
          rsp_pf_q    <= !pte_present;
          rsp_prot_q  <= pte_present && wr_q && pte_ro;
          if (pte_present) begin
            wb_valid_q                <= vld_q[cur_set][victim] && dty_q[cur_set][victim];
            wb_vpn_q                  <= {tag_q[cur_set][victim], cur_set};
            vld_q[cur_set][victim]    <= 1'b1;
            tag_q[cur_set][victim]    <= cur_tag;
            ppn_q[cur_set][victim]    <= pte_ppn;
            ro_q[cur_set][victim]     <= pte_ro;
            nc_q[cur_set][victim]     <= pte_nc;
            dty_q[cur_set][victim]    <= wr_q && !pte_ro;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (flush_i) for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end
  end

  assign busy_o           = (state_q != ST_IDLE);
  assign mem_req_valid_o  = (state_q == ST_REQ);
  assign mem_req_addr_o   = ptbr_q + (PA_W'(va_q[VA_W-1:PAGE_BITS]) << 2);
  assign rsp_valid_o      = rsp_valid_q;
  assign rsp_paddr_o      = rsp_paddr_q;
  assign rsp_ro_o         = rsp_ro_q;
  assign rsp_nc_o         = rsp_nc_q;
  assign rsp_page_fault_o = rsp_pf_q;
  assign rsp_prot_fault_o = rsp_prot_q;
  assign wb_valid_o       = wb_valid_q;
  assign wb_vpn_o         = wb_vpn_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            rsp_valid_o,
  input logic            rsp_page_fault_o,
  input logic            rsp_prot_fault_o,
  input logic            wb_valid_o,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_req_addr_o
);
  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R2
  busy_end_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> rsp_valid_o);

  // R4
  pf_no_install_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_page_fault_o |-> !wb_valid_o && !rsp_prot_fault_o);

  // R9
  wb_with_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> rsp_valid_o && !rsp_page_fault_o);
endmodule

bind tlb_xlate tlb_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .busy_o           (busy_o),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_page_fault_o (rsp_page_fault_o),
  .rsp_prot_fault_o (rsp_prot_fault_o),
  .wb_valid_o       (wb_valid_o),
  .mem_req_valid_o  (mem_req_valid_o),
  .mem_req_ready_i  (mem_req_ready_i),
  .mem_req_addr_o   (mem_req_addr_o)
);

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PTBR = 32'h0010_0000;
  localparam int NVEC = 10;
  // {write, exp_miss, exp_page_fault, exp_prot_fault, vaddr}
  localparam logic [35:0] VEC [NVEC] = '{
    {4'b0100, 32'h0001_0123},
    {4'b0000, 32'h0001_0FFF},
    {4'b1000, 32'h0001_0004},
    {4'b0110, 32'h8002_0000},
    {4'b0110, 32'h8002_0000},
    {4'b1101, 32'h4003_1004},
    {4'b0000, 32'h4003_1008},
    {4'b0100, 32'h2004_2ABC},
    {4'b1000, 32'h2004_2ABC},
    {4'b1001, 32'h4003_1000}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, flush, req_valid, req_write, mem_ready, mem_rvalid;
  logic [31:0] req_vaddr, mem_rdata;
  logic        busy, rsp_valid, rsp_ro, rsp_nc, rsp_pf, rsp_prot, wb_valid, mem_req_valid;
  logic [31:0] rsp_paddr, mem_req_addr;
  logic [19:0] wb_vpn;

  tlb_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .ptbr_i(PTBR),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_ro_o(rsp_ro), .rsp_nc_o(rsp_nc), .rsp_page_fault_o(rsp_pf),
    .rsp_prot_fault_o(rsp_prot), .wb_valid_o(wb_valid), .wb_vpn_o(wb_vpn),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rvalid),
    .mem_rsp_data_i(mem_rdata)
  );

  int n_chk = 0, n_bad = 0, miss_cnt = 0, mphase = 0;
  logic [31:0] cur_va = '0;
  logic r_miss, r_busy1, r_pf, r_prot, r_ro, r_nc, r_wb;
  logic [31:0] r_pa;
  logic [19:0] r_wbvpn;
  int r_lat;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // page table model: bit19 clear -> present, bit18 -> read-only, bit17 -> no-cache
  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    return {vpn ^ 20'h3C3C3, 9'b0, vpn[17], vpn[18], ~vpn[19]};
  endfunction

  function automatic logic [31:0] pa_of(input logic [31:0] va);
    return {va[31:12] ^ 20'h3C3C3, va[11:0]};
  endfunction

  // memory responder: ready one cycle, response two cycles later
  always @(negedge clk) begin
    if (!rst_n) begin
      mphase = 0; mem_ready = 1'b0; mem_rvalid = 1'b0;
    end else begin
      case (mphase)
        0: if (mem_req_valid) begin
             miss_cnt++;
             chk("R2 addr", mem_req_addr, PTBR + {10'b0, cur_va[31:12], 2'b00});
             mem_ready = 1'b1; mphase = 1;
           end
        1: begin mem_ready = 1'b0; mphase = 2; end
        2: begin mem_rvalid = 1'b1; mem_rdata = pte_of(cur_va[31:12]); mphase = 3; end
        default: begin mem_rvalid = 1'b0; mphase = 0; end
      endcase
    end
  end

  task automatic access(input logic [31:0] va, input logic w);
    int base;
    int waited;
    cur_va = va;
    base   = miss_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    r_busy1 = busy;
    waited = 0;
    while (!rsp_valid && waited < 60) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= 60) begin
      n_chk++; n_bad++;
      $display("FAIL R7 response timeout act=none exp=rsp");
    end
    r_lat  = waited;
    r_miss = (miss_cnt != base);
    r_pf = rsp_pf; r_prot = rsp_prot; r_pa = rsp_paddr;
    r_ro = rsp_ro; r_nc = rsp_nc; r_wb = wb_valid; r_wbvpn = wb_vpn;
  endtask

  task automatic expect_fill(input string req, input logic [31:0] va, input logic wb,
                             input logic [19:0] vpn);
    access(va, 1'b0);
    chk({req, " miss"}, 32'(r_miss), 32'd1);
    chk({req, " wb"}, 32'(r_wb), 32'(wb));
    if (wb) chk({req, " wb vpn"}, 32'(r_wbvpn), 32'(vpn));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11 mem_req", 32'(mem_req_valid), 32'd0);
    chk("R11 wb", 32'(wb_valid), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [35:0] v;
      v = VEC[i];
      access(v[31:0], v[35]);
      chk($sformatf("R3 vec%0d miss", i), 32'(r_miss), 32'(v[34]));
      chk($sformatf("R4 vec%0d page fault", i), 32'(r_pf), 32'(v[33]));
      chk($sformatf("R5 vec%0d prot fault", i), 32'(r_prot), 32'(v[32]));
      if (v[34]) chk($sformatf("R2 vec%0d busy", i), 32'(r_busy1), 32'd1);
      else       chk($sformatf("R1 vec%0d latency", i), 32'(r_lat), 32'd0);
      if (!v[33]) begin
        chk($sformatf("R5 vec%0d ro", i), 32'(r_ro), 32'(v[30]));
        chk($sformatf("R6 vec%0d nc", i), 32'(r_nc), 32'(v[29]));
        if (!v[32]) chk($sformatf("R1 vec%0d paddr", i), r_pa, pa_of(v[31:0]));
      end
    end

    // R8 LRU in set 0: 0x00010 (dirty) already resident
    expect_fill("R8 fill20", 32'h0002_0000, 1'b0, '0);
    expect_fill("R8 fill30", 32'h0003_0000, 1'b0, '0);
    expect_fill("R8 fill40", 32'h0004_0000, 1'b0, '0);
    access(32'h0001_0000, 1'b0);
    chk("R8 touch10 hit", 32'(r_miss), 32'd0);
    expect_fill("R8 fill50 evicts20", 32'h0005_0000, 1'b0, '0);
    expect_fill("R8 re20 missed", 32'h0002_0000, 1'b0, '0);
    expect_fill("R8 re30 missed", 32'h0003_0000, 1'b0, '0);
    // R9 dirty page 0x00010 is now the oldest
    expect_fill("R9 fill60 dirty evict", 32'h0006_0000, 1'b1, 20'h00010);
    expect_fill("R9 re10 missed", 32'h0001_0000, 1'b0, '0);

    // R5 write to read-only page 0x40031 left it clean: its eviction has no write-back
    expect_fill("R5 fill11", 32'h0001_1000, 1'b0, '0);
    expect_fill("R5 fill21", 32'h0002_1000, 1'b0, '0);
    expect_fill("R5 fill31", 32'h0003_1000, 1'b0, '0);
    expect_fill("R5 fill41 clean evict", 32'h0004_1000, 1'b0, '0);

    // R10 flush, and a request during flush is not accepted
    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_vaddr = 32'h2004_2ABC; req_write = 1'b0;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R10 no accept busy", 32'(busy), 32'd0);
    chk("R10 no accept rsp", 32'(rsp_valid), 32'd0);
    access(32'h2004_2ABC, 1'b0);
    chk("R10 flushed set2", 32'(r_miss), 32'd1);
    chk("R10 paddr after refill", r_pa, pa_of(32'h2004_2ABC));
    access(32'h0004_1000, 1'b0);
    chk("R10 flushed set1", 32'(r_miss), 32'd1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule